// File: doc/BRIEF.md
# Selectable-Source Half-Step Clock Divider

This block turns one of three source tick streams into a slow divided clock and a matching start-of-period strobe. Each source arrives as a single-cycle tick on a common fast system clock. Each tick stands for one edge of that source's doubled-rate clock. Counting at the doubled rate lets the block apply a prescale of 2, 2.5 or 3 with whole counts only. The total count per output period is N = (pre_code + 3) × int_div ticks of the chosen source.

Software sets the source selection, the prescale code, the integer divisor and an enable level. The block then produces `div_clk` and `div_pulse`. `div_clk` is high for the first floor(N/2) ticks of every period and low for the rest. `div_pulse` marks the first tick of each period. Any setting that is not valid holds both outputs low: enable low, prescale code 0, or an integer divisor below 2.

Top module: `halfstep_clkdiv`

## Requirements
- R1: With a valid setting, `div_clk` repeats every N = (pre_code+3)×int_div ticks of the selected source. It is high for the first floor(N/2) of those ticks. pre_code 1, 2 and 3 give prescale 2, 2.5 and 3.
- R2: pre_code = 0 holds `div_clk` and `div_pulse` low.
- R3: An int_div of 0 or 1 holds `div_clk` and `div_pulse` low.
- R4: While `div_en` is low, both outputs stay low. The first selected tick after `div_en` rises starts a period from count zero. `div_pulse` and `div_clk` go high in the cycle after that tick.
- R5: Source index is decoded from two select bits. `ext_sel`=0 picks `src_tick[0]` whatever `pll_sel` is. `ext_sel`=1 with `pll_sel`=0 picks `src_tick[1]`. `ext_sel`=1 with `pll_sel`=1 picks `src_tick[2]`. Ticks on unselected sources have no effect.
- R6: `div_pulse` is high for one system clock cycle per period, in the cycle where `div_clk` starts its high phase.
- R7: During reset both outputs are low.
- R8: The field extremes work: int_div = 127 with pre_code 1 or 3 gives N = 508 or 762.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than every source tick stream |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 3 | One tick per doubled-rate edge of each source |
| ext_sel | input | 1 | 0: reference source; 1: one of the two synthesized sources |
| pll_sel | input | 1 | Picks between the two synthesized sources when ext_sel is 1 |
| pre_code | input | 2 | Prescale code: 0 off, 1/2/3 give ratios 2/2.5/3 |
| int_div | input | 7 | Integer divisor, valid 2..127 |
| div_en | input | 1 | Output enable level |
| div_clk | output | 1 | Divided clock |
| div_pulse | output | 1 | One-cycle strobe at the start of each period |

## Verification
A table of settings covers each prescale code and several divisors, including odd N where floor(N/2) differs from N/2. It also covers the 127 extreme. Each setting is run with the selected source ticking every 1 to 4 cycles while the other sources tick every cycle, so choosing the wrong source or counting the wrong ticks shows up as a wrong period. Both select bit patterns that map to the reference source are included, to show that `pll_sel` is ignored there. Directed runs hold off code 0, divisor 0 and 1, and enable low for hundreds of cycles. They also check the exact restart cycle after the enable rises.

// File: rtl/halfstep_clkdiv_pkg.sv
package halfstep_clkdiv_pkg;
   localparam int NUM_SRC   = 3;
   localparam int SEL_W     = 2;
   localparam int DIV_W     = 7;
   localparam int PRE_W     = 2;
   localparam int MIN_DIV   = 2;

   typedef enum logic [SEL_W-1:0] {
      SRC_REF  = 2'd0,
      SRC_SYNA = 2'd1,
      SRC_SYNB = 2'd2
   } src_idx_e;

   function automatic src_idx_e decode_src(input logic ext, input logic pll);
      if (!ext)     return SRC_REF;
      else if (pll) return SRC_SYNB;
      else          return SRC_SYNA;
   endfunction
endpackage

// File: rtl/hsd_tick_mux.sv
module hsd_tick_mux #(
   parameter int N_IN  = 3,
   localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
   input  logic [N_IN-1:0]  ticks,
   input  logic [IDX_W-1:0] idx,
   output logic             tick_out
);
   logic [N_IN-1:0] hit;

   generate
      if (N_IN < 2) begin : g_bad
         $error("hsd_tick_mux needs at least two inputs");
      end
      for (genvar i = 0; i < N_IN; i++) begin : g_lane
         assign hit[i] = ticks[i] && (idx == IDX_W'(i));
      end
   endgenerate

   assign tick_out = |hit;
endmodule

// File: rtl/hsd_ratio_decode.sv
module hsd_ratio_decode #(
   parameter int DIV_W     = 7,
   parameter int PRE_W     = 2,
   parameter int MIN_DIV   = 2,
   parameter bit SHIFT_ADD = 1'b1,
   localparam int CNT_W    = DIV_W + 3
) (
   input  logic [PRE_W-1:0] pre,
   input  logic [DIV_W-1:0] idiv,
   input  logic             en,
   output logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] half,
   output logic             active
);
   logic [CNT_W-1:0] d_ext;
   assign d_ext = CNT_W'(idiv);

   generate
      if (PRE_W != 2) begin : g_bad
         $error("prescale code must be two bits");
      end
      if (SHIFT_ADD) begin : g_sa
         // ratio 4,5,6 = 4*d + d*(code-1)
         assign period = (d_ext << 2)
                       + ((pre >= PRE_W'(2)) ? d_ext : '0)
                       + ((pre == PRE_W'(3)) ? d_ext : '0);
      end else begin : g_mul
         logic [CNT_W-1:0] ratio;
         assign ratio  = CNT_W'(pre) + CNT_W'(3);
         assign period = ratio * d_ext;
      end
   endgenerate

   assign half   = period >> 1;
   assign active = en && (pre != '0) && (idiv >= DIV_W'(MIN_DIV));
endmodule

// File: rtl/hsd_period_counter.sv
module hsd_period_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             active,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] half,
   output logic [CNT_W-1:0] cnt,
   output logic             running,
   output logic             wave,
   output logic             start
);
   logic [CNT_W-1:0] cnt_n;
   logic             run_n;
   logic             start_n;

   always_comb begin
      cnt_n   = cnt;
      run_n   = running;
      start_n = 1'b0;
      if (!active) begin
         cnt_n = '0;
         run_n = 1'b0;
      end else if (tick) begin
         run_n = 1'b1;
         if (!running || (cnt >= period - CNT_W'(1))) begin
            cnt_n   = '0;
            start_n = 1'b1;
         end else begin
            cnt_n = cnt + CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
         wave    <= 1'b0;
         start   <= 1'b0;
      end else begin
         cnt     <= cnt_n;
         running <= run_n;
         wave    <= run_n && (cnt_n < half);
         start   <= start_n;
      end
   end

   // R4: a fresh run always begins at count zero
   a_r4_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> (cnt == '0) && start);
   // R6: strobe lasts a single cycle
   a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);
endmodule

// File: rtl/halfstep_clkdiv.sv
module halfstep_clkdiv
   import halfstep_clkdiv_pkg::*;
#(
   parameter bit SHIFT_ADD = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic               ext_sel,
   input  logic               pll_sel,
   input  logic [PRE_W-1:0]   pre_code,
   input  logic [DIV_W-1:0]   int_div,
   input  logic               div_en,
   output logic               div_clk,
   output logic               div_pulse
);
   localparam int CNT_W = DIV_W + 3;
   localparam int IDX_W = $clog2(NUM_SRC);

   generate
      if (IDX_W != SEL_W) begin : g_bad_sel
         $error("source index width mismatch");
      end
      if (MIN_DIV < 2) begin : g_bad_min
         $error("minimum divisor must be at least 2");
      end
   endgenerate

   src_idx_e         sel_idx;
   logic             tick_sel;
   logic [CNT_W-1:0] period;
   logic [CNT_W-1:0] half;
   logic             active;
   logic [CNT_W-1:0] cnt;
   logic             running;

   assign sel_idx = decode_src(ext_sel, pll_sel);

   hsd_tick_mux #(.N_IN(NUM_SRC)) u_mux (
      .ticks    (src_tick),
      .idx      (sel_idx),
      .tick_out (tick_sel)
   );

   hsd_ratio_decode #(
      .DIV_W(DIV_W), .PRE_W(PRE_W), .MIN_DIV(MIN_DIV), .SHIFT_ADD(SHIFT_ADD)
   ) u_dec (
      .pre    (pre_code),
      .idiv   (int_div),
      .en     (div_en),
      .period (period),
      .half   (half),
      .active (active)
   );

   hsd_period_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_sel),
      .active  (active),
      .period  (period),
      .half    (half),
      .cnt     (cnt),
      .running (running),
      .wave    (div_clk),
      .start   (div_pulse)
   );

   // R2 R3 R4: an invalid or disabled setting silences both outputs
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !div_clk && !div_pulse);
   // R6: strobe coincides with the high phase
   a_r6_pulse_high: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |-> div_clk && (cnt == '0));
   // R1: a running counter holds a valid output only while active
   a_r1_run_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> $past(active));
   // R7: reset clears the outputs
   a_r7_reset_low: assert property (@(posedge clk)
      !rst_n |=> !div_clk && !div_pulse);
endmodule

// File: tb/halfstep_clkdiv_tb.sv
module halfstep_clkdiv_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] src_tick = 3'b000;
   logic       ext_sel = 1'b0, pll_sel = 1'b0;
   logic [1:0] pre_code = 2'd0;
   logic [6:0] int_div = 7'd0;
   logic       div_en = 1'b0;
   logic       div_clk, div_pulse;

   int n_run = 0, n_fail = 0, cyc = 0;
   int cfg_idx = 0, cfg_gap = 1;

   always #10 clk = ~clk;

   halfstep_clkdiv dut_i (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ext_sel(ext_sel),
      .pll_sel(pll_sel), .pre_code(pre_code), .int_div(int_div),
      .div_en(div_en), .div_clk(div_clk), .div_pulse(div_pulse)
   );

   // tick generator: selected source every cfg_gap cycles, others every cycle
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         ph = (ph + 1 >= cfg_gap) ? 0 : ph + 1;
         for (int s = 0; s < 3; s++)
            src_tick[s] = (s == cfg_idx) ? (ph == 0) : 1'b1;
      end
   end

   // fields: ext, pll, pre[1:0], div[6:0], gap[3:0]
   localparam logic [14:0] VEC [8] = '{
      {1'b0, 1'b0, 2'd1, 7'd2,   4'd1},
      {1'b0, 1'b1, 2'd2, 7'd3,   4'd2},
      {1'b1, 1'b0, 2'd3, 7'd5,   4'd3},
      {1'b1, 1'b1, 2'd2, 7'd7,   4'd2},
      {1'b1, 1'b1, 2'd1, 7'd127, 4'd1},
      {1'b0, 1'b0, 2'd3, 7'd127, 4'd1},
      {1'b1, 1'b0, 2'd2, 7'd2,   4'd4},
      {1'b0, 1'b0, 2'd2, 7'd9,   4'd1}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic measure(output int per, output int hi, output bit ok);
      int w = 0;
      per = 0; hi = 0; ok = 0;
      @(negedge clk);
      while (!div_pulse && w < 5000) begin @(negedge clk); w++; end
      if (!div_pulse) return;
      do begin
         if (div_clk) hi++;
         per++;
         @(negedge clk);
      end while (!div_pulse && per < 5000);
      ok = div_pulse;
   endtask

   task automatic quiet_run(input string req, input int len);
      int bad = 0;
      repeat (2) @(negedge clk);
      for (int k = 0; k < len; k++) begin
         if (div_clk || div_pulse) bad++;
         @(negedge clk);
      end
      check(bad == 0, req, bad, 0);
   endtask

   initial begin
      cyc = 0;
      forever begin
         @(posedge clk); cyc++;
         if (cyc > 190000) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
         end
      end
   end

   initial begin
      int per, hi, exp_per, exp_hi, n, g;
      bit ok;
      // R7: reset state
      div_en = 1'b1; pre_code = 2'd1; int_div = 7'd2;
      repeat (4) @(negedge clk);
      check(!div_clk && !div_pulse, "R7 reset", {div_clk, div_pulse}, 0);
      rst_n = 1'b1;

      // R1 R5 R8: table of settings
      foreach (VEC[i]) begin
         div_en   = 1'b0;
         ext_sel  = VEC[i][14];
         pll_sel  = VEC[i][13];
         pre_code = VEC[i][12:11];
         int_div  = VEC[i][10:4];
         g        = int'(VEC[i][3:0]);
         cfg_gap  = g;
         cfg_idx  = !ext_sel ? 0 : (pll_sel ? 2 : 1);
         repeat (2) @(negedge clk);
         div_en = 1'b1;
         n = (int'(pre_code) + 3) * int'(int_div);
         exp_per = n * g;
         exp_hi  = (n / 2) * g;
         measure(per, hi, ok);
         check(ok && per == exp_per, "R1/R5/R8 period", per, exp_per);
         check(ok && hi == exp_hi, "R1 high time", hi, exp_hi);
      end

      cfg_idx = 0; cfg_gap = 1; ext_sel = 1'b0; pll_sel = 1'b0;
      // R2: prescale code zero
      pre_code = 2'd0; int_div = 7'd9; div_en = 1'b1;
      quiet_run("R2 code0", 300);
      // R3: divisor 0 and 1
      pre_code = 2'd2; int_div = 7'd0;
      quiet_run("R3 div0", 300);
      int_div = 7'd1;
      quiet_run("R3 div1", 300);
      // R4: enable low, then exact restart
      int_div = 7'd2; pre_code = 2'd1; div_en = 1'b0;
      quiet_run("R4 enable low", 300);
      div_en = 1'b1;
      @(negedge clk);
      check(div_pulse && div_clk, "R4 restart pulse", {div_pulse, div_clk}, 3);
      @(negedge clk);
      check(!div_pulse, "R6 pulse width", div_pulse, 0);
      repeat (2) @(negedge clk);
      check(div_clk, "R4 still high at count 3", div_clk, 1);
      @(negedge clk);
      check(!div_clk, "R4 low at count 4", div_clk, 0);
      // R6: one pulse per period over several periods
      begin
         int pulses = 0;
         for (int k = 0; k < 80; k++) begin
            if (div_pulse) pulses++;
            @(negedge clk);
         end
         check(pulses == 10, "R6 pulses per 80 cycles", pulses, 10);
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule